// File: doc/BRIEF.md
# Third-Order Sinc Decimation Channel

This block takes a one-bit oversampled stream from a delta-sigma modulator and turns it into 24-bit decimated samples. It uses a cascade of three integrators that run at the input rate, a decimator, and three comb sections that run at the output rate. A two-bit select picks the decimation ratio. The comb output is scaled so that full scale maps onto 24 bits in every ratio.

Each finished sample is stored in an output buffer. A bus reads the buffer as a 16-bit upper word and an 8-bit lower byte. When a sample lands, a ready flag goes high. An interrupt request goes with the flag and is gated by a single enable input. Reading the upper word clears the flag, so the intended order is to read the lower byte first and the upper word last.

Top module: `sinc3_decim_channel`

## Requirements
- R1: After reset the upper word reads 0xFFFF, the lower byte reads 0xFF, and both `buf_full` and `irq` are 0.
- R2: An input bit counts as +1 when it is 1 and 0 when it is 0. It is taken only in a cycle with `in_valid` high. Each stored sample equals S*2^24/R^3 clamped to 0xFFFFFF. S is the third-order sinc response: the sum over the most recent 3R-1 accepted bits of the triple-boxcar weight h3(n) times the bit. Bits from before reset or before a restart count as 0.
- R3: The `osr_sel` codes 0, 1, 2 and 3 give decimation ratios R of 64, 128, 256 and 512. Exactly one sample completes on every R-th accepted bit.
- R4: Both halves of a sample are captured at the clock edge that ends the cycle of the completing bit, and `buf_full` is 1 from that edge on. Between completions the stored upper word and lower byte do not change.
- R5: A read with `rd_en`=1 and `rd_addr`=0 (upper word) clears `buf_full` at that edge. A read with `rd_en`=1 and `rd_addr`=1 (lower byte) leaves `buf_full` unchanged.
- R6: If a sample completes in the same cycle as an upper-word read, `buf_full` stays 1 and the buffer holds the new sample.
- R7: `irq` is 1 exactly when `buf_full` is 1 and `irq_en` is 1.
- R8: A cycle in which `osr_sel` differs from the ratio in use is a restart cycle. It clears the integrators, comb history and decimation count, and it drops any bit offered in that cycle. The output buffer and `buf_full` keep their values.
- R9: `rd_data` follows `rd_addr` combinationally. Address 0 returns the upper 16 bits of the sample (bits 23:8). Address 1 returns the lower 8 bits (bits 7:0) in `rd_data[7:0]`, with zeros in bits 15:8.
- R10: A steady all-ones stream saturates to 0xFFFFFF once a full 3R-1 window has been seen. A steady alternating stream settles at 0x800000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_bit | input | 1 | Modulator bit |
| in_valid | input | 1 | Marks a cycle carrying a modulator bit |
| osr_sel | input | 2 | Decimation ratio select |
| irq_en | input | 1 | Interrupt enable |
| rd_en | input | 1 | Read strobe; an upper-word read clears the flag |
| rd_addr | input | 1 | 0 selects the upper word, 1 selects the lower byte |
| rd_data | output | 16 | Read data |
| buf_full | output | 1 | A sample is waiting |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a sample that completes in the very cycle an upper-word read arrives, because the completion edge is buried behind a decimation counter. The bench counts every accepted bit itself. In the cycle of the R-th bit it issues the clearing read, then checks that the flag survived and that the buffer holds the new sample. A restart is also driven with a bit offered during the restart cycle. The scoreboard has no record of that bit, so a design that accepted it would produce a wrong sample.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

  localparam int SINC_ORDER = 3;

  typedef enum logic {
    SEL_HI = 1'b0,
    SEL_LO = 1'b1
  } rd_sel_e;

  // log2 of the decimation ratio chosen by a select code
  function automatic int ratio_log2(int base_log2, int osr_code);
    return base_log2 + osr_code;
  endfunction

  // accumulator width: holds R_max^ORDER exactly, plus one bit
  function automatic int acc_width(int base_log2, int osr_w);
    return SINC_ORDER * (base_log2 + (1 << osr_w) - 1) + 1;
  endfunction

  // right-shift (positive) or left-shift (negative) that maps the filter gain onto out_w bits
  function automatic int gain_shift(int base_log2, int osr_code, int out_w);
    return SINC_ORDER * ratio_log2(base_log2, osr_code) - out_w;
  endfunction

endpackage

// File: rtl/sinc3_integrator.sv
module sinc3_integrator
  import sinc3_pkg::*;
#(
  parameter int ACC_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic             in_bit,
  output logic [ACC_W-1:0] integ_out
);

  logic [ACC_W-1:0] acc_q  [SINC_ORDER];
  logic [ACC_W-1:0] acc_nx [SINC_ORDER];
  logic [ACC_W-1:0] ext_bit;

  assign ext_bit = {{(ACC_W-1){1'b0}}, in_bit};

  for (genvar g = 0; g < SINC_ORDER; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign acc_nx[g] = acc_q[g] + ext_bit;
    end else begin : g_rest
      assign acc_nx[g] = acc_q[g] + acc_nx[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc_q[g] <= '0;
      else if (clear) acc_q[g] <= '0;
      else if (step)  acc_q[g] <= acc_nx[g];
    end
  end

  assign integ_out = acc_nx[SINC_ORDER-1];

  // R2
  integ_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(acc_q[0]));

endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
  import sinc3_pkg::*;
#(
  parameter int BASE_LOG2 = 6,
  parameter int OSR_W     = 2,
  parameter int CNT_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  input  logic [OSR_W-1:0] osr,
  output logic             dec_stb
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;
  logic             at_last;
  int               rl;

  assign rl = ratio_log2(BASE_LOG2, int'(osr));

  always_comb begin
    last_val = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i < rl) last_val[i] = 1'b1;
    end
  end

  assign at_last = (cnt_q == last_val);
  assign dec_stb = step && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (step)  cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  // R3
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_val);

  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stb |=> (cnt_q == '0));

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb
  import sinc3_pkg::*;
#(
  parameter int ACC_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             stb,
  input  logic [ACC_W-1:0] d_in,
  output logic [ACC_W-1:0] comb_out
);

  logic [ACC_W-1:0] dly_q    [SINC_ORDER];
  logic [ACC_W-1:0] stage_in [SINC_ORDER];
  logic [ACC_W-1:0] diff     [SINC_ORDER];

  for (genvar g = 0; g < SINC_ORDER; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stage_in[g] = d_in;
    end else begin : g_rest
      assign stage_in[g] = diff[g-1];
    end
    assign diff[g] = stage_in[g] - dly_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dly_q[g] <= '0;
      else if (clear) dly_q[g] <= '0;
      else if (stb)   dly_q[g] <= stage_in[g];
    end
  end

  assign comb_out = diff[SINC_ORDER-1];

  // R2
  comb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb && !clear) |=> $stable(dly_q[0]));

endmodule

// File: rtl/sinc3_out_buffer.sv
module sinc3_out_buffer
  import sinc3_pkg::*;
#(
  parameter int OUT_W = 24,
  parameter int HI_W  = 16,
  localparam int LO_W = OUT_W - HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OUT_W-1:0] res_in,
  input  logic             rd_en,
  input  logic             rd_addr,
  input  logic             irq_en,
  output logic [HI_W-1:0]  rd_data,
  output logic             buf_full,
  output logic             irq
);

  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_q;
  logic            full_q;
  logic            hi_rd;

  assign hi_rd = rd_en && (rd_addr == SEL_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '1;
      lo_q <= '1;
    end else if (load) begin
      hi_q <= res_in[OUT_W-1 -: HI_W];
      lo_q <= res_in[LO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     full_q <= 1'b0;
    else if (load)  full_q <= 1'b1;
    else if (hi_rd) full_q <= 1'b0;
  end

  assign rd_data  = (rd_addr == SEL_LO) ? {{(HI_W-LO_W){1'b0}}, lo_q} : hi_q;
  assign buf_full = full_q;
  assign irq      = full_q & irq_en;

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> buf_full);

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_rd && !load) |=> !buf_full);

  // R5
  lo_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr == SEL_LO) && buf_full) |=> buf_full);

  // R4
  halves_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(hi_q) && $stable(lo_q)));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (buf_full && irq_en));

endmodule

// File: rtl/sinc3_decim_channel.sv
module sinc3_decim_channel
  import sinc3_pkg::*;
#(
  parameter int BASE_LOG2 = 6,
  parameter int OSR_W     = 2,
  parameter int OUT_W     = 24,
  parameter int HI_W      = 16,
  localparam int ACC_W    = acc_width(BASE_LOG2, OSR_W),
  localparam int CNT_W    = BASE_LOG2 + (1 << OSR_W) - 1,
  localparam int WIDE_W   = ACC_W + OUT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_bit,
  input  logic             in_valid,
  input  logic [OSR_W-1:0] osr_sel,
  input  logic             irq_en,
  input  logic             rd_en,
  input  logic             rd_addr,
  output logic [HI_W-1:0]  rd_data,
  output logic             buf_full,
  output logic             irq
);

  logic [OSR_W-1:0] osr_q;
  logic             restart;
  logic             step;
  logic             dec_stb;
  logic [ACC_W-1:0] integ_out;
  logic [ACC_W-1:0] comb_out;
  logic [WIDE_W-1:0] wide;
  logic [WIDE_W-1:0] shifted;
  logic [OUT_W-1:0] result;
  int               sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       osr_q <= '0;
    else if (restart) osr_q <= osr_sel;
  end

  assign restart = (osr_sel != osr_q);
  assign step    = in_valid && !restart;

  sinc3_integrator #(.ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst_n(rst_n), .clear(restart), .step(step),
    .in_bit(in_bit), .integ_out(integ_out)
  );

  sinc3_decimator #(.BASE_LOG2(BASE_LOG2), .OSR_W(OSR_W), .CNT_W(CNT_W)) u_decim (
    .clk(clk), .rst_n(rst_n), .clear(restart), .step(step),
    .osr(osr_q), .dec_stb(dec_stb)
  );

  sinc3_comb #(.ACC_W(ACC_W)) u_comb (
    .clk(clk), .rst_n(rst_n), .clear(restart), .stb(dec_stb),
    .d_in(integ_out), .comb_out(comb_out)
  );

  // scale the filter gain R^3 onto OUT_W bits; saturate the single full-scale case
  assign sh   = gain_shift(BASE_LOG2, int'(osr_q), OUT_W);
  assign wide = {{OUT_W{1'b0}}, comb_out};

  always_comb begin
    if (sh >= 0) shifted = wide >> sh;
    else         shifted = wide << (-sh);
    if (|shifted[WIDE_W-1:OUT_W]) result = '1;
    else                          result = shifted[OUT_W-1:0];
  end

  sinc3_out_buffer #(.OUT_W(OUT_W), .HI_W(HI_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(dec_stb), .res_in(result),
    .rd_en(rd_en), .rd_addr(rd_addr), .irq_en(irq_en),
    .rd_data(rd_data), .buf_full(buf_full), .irq(irq)
  );

  // R8
  restart_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> !dec_stb);

  // R8
  restart_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !rd_en) |=> (buf_full == $past(buf_full)));

endmodule

// File: tb/sinc3_decim_channel_tb.sv
module sinc3_decim_channel_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_bit, in_valid, irq_en, rd_en, rd_addr;
  logic [1:0]  osr_sel;
  logic [15:0] rd_data;
  logic        buf_full, irq;

  always #10 clk = ~clk;

  sinc3_decim_channel u_dut (
    .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_valid(in_valid),
    .osr_sel(osr_sel), .irq_en(irq_en), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .buf_full(buf_full), .irq(irq)
  );

  int          n_checks = 0;
  int          n_fail   = 0;
  logic [23:0] exp_q[$];
  bit          hist[0:4095];
  int          n_hist = 0;
  int          cur_r  = 64;
  longint      h3[0:1535];
  bit          mon_on = 0;
  logic [23:0] last_seen = '0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // triple boxcar weights built as two convolutions
  function automatic void build_h(int r);
    for (int n = 0; n <= 3*r-2; n++) begin
      longint s = 0;
      for (int j = 0; j < r; j++) begin
        int m = n - j;
        if (m >= 0 && m <= 2*r-2) s += ((m+1) < (2*r-1-m)) ? (m+1) : (2*r-1-m);
      end
      h3[n] = s;
    end
  endfunction

  function automatic logic [23:0] expect_now();
    longint s = 0;
    longint r3 = longint'(cur_r) * cur_r * cur_r;
    longint v;
    for (int n = 0; n <= 3*cur_r-2; n++) begin
      int idx = n_hist - 1 - n;
      if (idx >= 0 && hist[idx]) s += h3[n];
    end
    v = (s << 24) / r3;
    if (v > 64'hFFFFFF) v = 64'hFFFFFF;
    return v[23:0];
  endfunction

  // driver: one accepted bit per call, called at a falling edge
  task automatic push_bit(bit b, bit rd_same);
    in_bit = b; in_valid = 1'b1;
    if (rd_same) begin rd_en = 1'b1; rd_addr = 1'b0; end
    hist[n_hist] = b; n_hist++;
    if (n_hist % cur_r == 0) exp_q.push_back(expect_now());
    @(negedge clk);
    in_valid = 1'b0;
    if (rd_same) rd_en = 1'b0;
  endtask

  // restart with a bit offered in the restart cycle (it must be dropped)
  task automatic set_osr(logic [1:0] code);
    osr_sel = code; in_bit = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    cur_r = 64 << code;
    build_h(cur_r);
    n_hist = 0;
  endtask

  task automatic read_now(output logic [23:0] v);
    logic [15:0] hi, lo;
    rd_addr = 1'b0; #1 hi = rd_data;
    rd_addr = 1'b1; #1 lo = rd_data;
    rd_addr = 1'b0;
    v = {hi, lo[7:0]};
  endtask

  // monitor: pops the scoreboard whenever a sample is waiting
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && buf_full) begin
        logic [15:0] hi, lo;
        logic [23:0] e;
        check("R7 irq follows flag", {31'd0, irq}, {31'd0, irq_en});
        rd_addr = 1'b0; #1 hi = rd_data;
        rd_addr = 1'b1; #1 lo = rd_data;
        check("R9 low byte upper zero", {24'd0, lo[15:8]}, 32'd0);
        if (exp_q.size() == 0) begin
          check("R3 unexpected sample", 32'd1, 32'd0);
        end else begin
          e = exp_q.pop_front();
          check("R2 sample value", {8'd0, hi, lo[7:0]}, {8'd0, e});
        end
        last_seen = {hi, lo[7:0]};
        rd_addr = 1'b0; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        #1 check("R5 high read clears", {31'd0, buf_full}, 32'd0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [23:0] v, e;
    rst_n = 1'b0; in_bit = 0; in_valid = 0; osr_sel = 2'd0;
    irq_en = 1'b1; rd_en = 0; rd_addr = 0;
    build_h(64);
    repeat (3) @(negedge clk);
    rd_addr = 1'b0; #1 check("R1 reset high word", {16'd0, rd_data}, 32'h0000FFFF);
    rd_addr = 1'b1; #1 check("R1 reset low byte", {16'd0, rd_data}, 32'h000000FF);
    check("R1 reset flag", {31'd0, buf_full}, 32'd0);
    check("R1 reset irq", {31'd0, irq}, 32'd0);
    rd_addr = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // random stream, ratio 64
    mon_on = 1'b1;
    for (int i = 0; i < 64*6; i++) push_bit(1'($urandom), 0);
    repeat (4) @(negedge clk);

    // all ones, ratio 128 -> saturation
    set_osr(2'd1);
    for (int i = 0; i < 128*4; i++) push_bit(1'b1, 0);
    repeat (4) @(negedge clk);
    check("R10 all ones saturate", {8'd0, last_seen}, 32'h00FFFFFF);

    // alternating, ratio 256 -> half scale
    set_osr(2'd2);
    for (int i = 0; i < 256*4; i++) push_bit(1'(i % 2 == 0), 0);
    repeat (4) @(negedge clk);
    check("R10 alternating mid scale", {8'd0, last_seen}, 32'h00800000);

    // random, ratio 512
    set_osr(2'd3);
    for (int i = 0; i < 512*3; i++) push_bit(1'($urandom), 0);
    repeat (4) @(negedge clk);
    mon_on = 1'b0;

    // interrupt gating and low-byte read
    irq_en = 1'b0;
    set_osr(2'd0);
    for (int i = 0; i < 64; i++) push_bit(1'b1, 0);
    check("R4 flag after completion", {31'd0, buf_full}, 32'd1);
    check("R7 irq masked", {31'd0, irq}, 32'd0);
    read_now(v); e = exp_q.pop_front();
    check("R4 captured sample", {8'd0, v}, {8'd0, e});
    rd_en = 1'b1; rd_addr = 1'b1; @(negedge clk); rd_en = 1'b0; rd_addr = 1'b0;
    check("R5 low read keeps flag", {31'd0, buf_full}, 32'd1);
    irq_en = 1'b1; #1
    check("R7 irq enabled", {31'd0, irq}, 32'd1);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    check("R5 high read clears", {31'd0, buf_full}, 32'd0);
    check("R7 irq drops", {31'd0, irq}, 32'd0);

    // completion and clearing read in the same cycle
    for (int i = 0; i < 64; i++) push_bit(1'($urandom), 0);
    read_now(v); e = exp_q.pop_front();
    check("R4 first sample held", {8'd0, v}, {8'd0, e});
    for (int i = 0; i < 63; i++) push_bit(1'($urandom), 0);
    push_bit(1'b1, 1);
    check("R6 set wins over clear", {31'd0, buf_full}, 32'd1);
    read_now(v); e = exp_q.pop_front();
    check("R6 new sample stored", {8'd0, v}, {8'd0, e});
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;

    // restart mid-window keeps the buffer and discards history
    for (int i = 0; i < 30; i++) push_bit(1'b1, 0);
    set_osr(2'd1);
    read_now(v);
    check("R8 buffer kept over restart", {8'd0, v}, {8'd0, e});
    check("R8 flag kept over restart", {31'd0, buf_full}, 32'd0);
    mon_on = 1'b1;
    for (int i = 0; i < 128*2; i++) push_bit(1'($urandom), 0);
    repeat (4) @(negedge clk);
    mon_on = 1'b0;

    check("R3 one sample per R bits", exp_q.size(), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule